// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block keeps a small ring of transmit descriptors in internal registers and streams the buffers they describe out of a byte-wide valid/ready port. The host queues a frame by presenting a length and a buffer pointer on the submit port. If the length is legal and a slot is free, the block writes the descriptor at its producer position and marks it ready for transmission, as the final piece of a frame that needs a hardware CRC appended. A one-cycle kick pulse wakes the engine. The engine then walks the ring from its current position and sends every ready descriptor until it meets one that is not ready. The ring closes at the slot that carries the wrap flag.

When a buffer has been fully sent, its ready flag is dropped. A reclaim stage then walks the ring from the oldest used slot. It scrubs each slot that is no longer ready, leaving only the wrap flag on the final slot, and returns the slot to the free count. It stops at the first slot that is still ready. The host reads the free count to see how many slots remain.

A graceful-stop control lets the frame in flight finish and then parks the engine. Two event bits report completed frames and a completed stop, and the host clears them by writing ones.

Top module: `txr_engine`

## Requirements
- R1: After reset the free count equals the ring size (4 by default), both event bits are 0, and no stream byte is offered.
- R2: A submission is accepted (sub_ok high in the same cycle) only when its length is in 1..1500 and the free count is non-zero. A refused submission leaves the free count unchanged, and no frame is sent for it.
- R3: The engine stays idle until a kick pulse. It then sends the ready descriptors in ring order from its current slot and stops at the first slot that is not ready. Byte i of a buffer is the value on buf_data while buf_addr equals pointer+i.
- R4: Every descriptor made by a submission is the final piece of its frame and requests a CRC. m_crc is high with every byte of such a buffer, and m_last is high on its final byte only.
- R5: While m_valid is high and m_ready is low, m_data, m_last and m_crc hold their values.
- R6: After the slot that carries the wrap flag (the slot at index ring size minus 1), the engine continues at slot 0, so frames go out in submission order across several passes of the ring.
- R7: Sent slots return to the free count in ring order, starting at the oldest used slot. Reclaim stops at a slot that is still ready, so queued but unsent slots stay counted as used. The free count never exceeds the ring size.
- R8: When a submission and a reclaim fall in the same cycle, the free count ends that cycle unchanged.
- R9: When stop_req is high, the frame in flight completes, no further byte is offered while stop_req stays high, and event bit 1 (stop complete) is set. Once stop_req is low, a kick resumes transmission.
- R10: Event bit 0 (frame sent) is set in the cycle that accepts the final byte of a buffer. Writing 1 to a bit of evt_clr clears that event bit. When a set and a clear of the same bit fall in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_valid | input | 1 | Submit a frame this cycle |
| sub_len | input | 11 | Frame length in bytes |
| sub_ptr | input | 16 | Buffer start address |
| sub_ok | output | 1 | Submission accepted this cycle |
| kick | input | 1 | Task-enable pulse that starts a ring scan |
| stop_req | input | 1 | Graceful-stop request (level) |
| m_valid | output | 1 | Stream byte valid |
| m_ready | input | 1 | Stream sink ready |
| m_data | output | 8 | Stream byte |
| m_last | output | 1 | Final byte of a frame |
| m_crc | output | 1 | Frame requests a CRC append |
| buf_addr | output | 16 | Buffer read address |
| buf_data | input | 8 | Buffer read data (combinational) |
| free_cnt | output | 3 | Number of free descriptor slots |
| evt | output | 2 | Events: bit 0 frame sent, bit 1 stop complete |
| evt_clr | input | 2 | Write-one-to-clear for evt |

## Verification
The reclaim stage and the submit port both change the free count, and they can act in the same cycle. The bench provokes this by sending a one-byte frame and raising a new submission on the cycle right after the final byte is accepted. That is exactly the cycle in which the sent slot is reclaimed, and the bench expects the free count to stay unchanged. In the cycle that accepts that final byte, the bench also writes a clear of the frame-sent event, so a set and a clear of the same event bit coincide, and it expects the bit to remain set.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_FETCH = 2'd1,
    ENG_SEND  = 2'd2,
    ENG_HALT  = 2'd3
  } eng_state_t;

  localparam int EV_SENT = 0;
  localparam int EV_STOP = 1;
  localparam int EV_W    = 2;
endpackage

// File: rtl/txr_desc_ring.sv
module txr_desc_ring #(
  parameter int RING_N  = 4,
  parameter int LEN_W   = 11,
  parameter int AW      = 16,
  parameter int MAX_LEN = 1500,
  localparam int IW     = (RING_N > 1) ? $clog2(RING_N) : 1,
  localparam int CW     = $clog2(RING_N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sub_valid,
  input  logic [LEN_W-1:0] sub_len,
  input  logic [AW-1:0]    sub_ptr,
  output logic             sub_ok,
  input  logic [IW-1:0]    rd_idx,
  output logic             rd_ready,
  output logic             rd_wrap,
  output logic             rd_last,
  output logic             rd_crc,
  output logic [LEN_W-1:0] rd_len,
  output logic [AW-1:0]    rd_ptr,
  input  logic             done_pulse,
  input  logic [IW-1:0]    done_idx,
  output logic [CW-1:0]    free_cnt
);
  logic [RING_N-1:0]    st_ready, st_last, st_crc, st_wrap;
  logic [LEN_W-1:0]     d_len [RING_N];
  logic [AW-1:0]        d_ptr [RING_N];
  logic [IW-1:0]        prod_q, prod_d, recl_q, recl_d;
  logic [CW-1:0]        free_d;
  logic                 recl_go, len_ok;

  assign len_ok  = (sub_len != '0) && (sub_len <= LEN_W'(MAX_LEN));
  assign sub_ok  = sub_valid && len_ok && (free_cnt != '0);
  assign recl_go = (free_cnt != CW'(RING_N)) && !st_ready[recl_q];

  always_comb begin
    prod_d = prod_q;
    recl_d = recl_q;
    free_d = free_cnt;
    if (sub_ok)
      prod_d = (prod_q == IW'(RING_N - 1)) ? '0 : prod_q + 1'b1;
    if (recl_go)
      recl_d = (recl_q == IW'(RING_N - 1)) ? '0 : recl_q + 1'b1;
    case ({sub_ok, recl_go})
      2'b10:   free_d = free_cnt - 1'b1;
      2'b01:   free_d = free_cnt + 1'b1;
      default: free_d = free_cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q   <= '0;
      recl_q   <= '0;
      free_cnt <= CW'(RING_N);
    end else begin
      prod_q   <= prod_d;
      recl_q   <= recl_d;
      free_cnt <= free_d;
    end
  end

  for (genvar s = 0; s < RING_N; s++) begin : g_slot
    logic wr_en, clr_rdy, scrub;
    assign wr_en   = sub_ok && (prod_q == IW'(s));
    assign clr_rdy = done_pulse && (done_idx == IW'(s));
    assign scrub   = recl_go && (recl_q == IW'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_ready[s] <= 1'b0;
        st_last[s]  <= 1'b0;
        st_crc[s]   <= 1'b0;
        st_wrap[s]  <= (s == RING_N - 1);
        d_len[s]    <= '0;
        d_ptr[s]    <= '0;
      end else begin
        if (wr_en) begin
          st_ready[s] <= 1'b1;
          st_last[s]  <= 1'b1;
          st_crc[s]   <= 1'b1;
          d_len[s]    <= sub_len;
          d_ptr[s]    <= sub_ptr;
        end else if (scrub) begin
          st_ready[s] <= 1'b0;
          st_last[s]  <= 1'b0;
          st_crc[s]   <= 1'b0;
          st_wrap[s]  <= (s == RING_N - 1);
        end else if (clr_rdy) begin
          st_ready[s] <= 1'b0;
        end
      end
    end
  end

  assign rd_ready = st_ready[rd_idx];
  assign rd_wrap  = st_wrap[rd_idx];
  assign rd_last  = st_last[rd_idx];
  assign rd_crc   = st_crc[rd_idx];
  assign rd_len   = d_len[rd_idx];
  assign rd_ptr   = d_ptr[rd_idx];
endmodule

// File: rtl/txr_fetch.sv
module txr_fetch
  import txr_pkg::*;
#(
  parameter int RING_N = 4,
  parameter int LEN_W  = 11,
  parameter int AW     = 16,
  localparam int IW    = (RING_N > 1) ? $clog2(RING_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic             stop_req,
  output logic [IW-1:0]    rd_idx,
  input  logic             rd_ready,
  input  logic             rd_wrap,
  input  logic             rd_last,
  input  logic             rd_crc,
  input  logic [LEN_W-1:0] rd_len,
  input  logic [AW-1:0]    rd_ptr,
  output logic             done_pulse,
  output logic             frame_sent,
  output logic             stop_done,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [7:0]       m_data,
  output logic             m_last,
  output logic             m_crc,
  output logic [AW-1:0]    buf_addr,
  input  logic [7:0]       buf_data
);
  eng_state_t       st_q, st_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [LEN_W-1:0] len_q, cnt_q, cnt_d;
  logic [AW-1:0]    ptr_q;
  logic             last_q, crc_q, wrap_q, load, byte_end, take;

  assign byte_end = (cnt_q == len_q - 1'b1);
  assign take     = (st_q == ENG_SEND) && m_ready;

  always_comb begin
    st_d       = st_q;
    idx_d      = idx_q;
    cnt_d      = cnt_q;
    load       = 1'b0;
    done_pulse = 1'b0;
    stop_done  = 1'b0;
    case (st_q)
      ENG_IDLE: begin
        if (stop_req) begin
          st_d      = ENG_HALT;
          stop_done = 1'b1;
        end else if (kick) begin
          st_d = ENG_FETCH;
        end
      end
      ENG_FETCH: begin
        if (stop_req) begin
          st_d      = ENG_HALT;
          stop_done = 1'b1;
        end else if (rd_ready) begin
          st_d  = ENG_SEND;
          load  = 1'b1;
          cnt_d = '0;
        end else begin
          st_d = ENG_IDLE;
        end
      end
      ENG_SEND: begin
        if (take) begin
          if (byte_end) begin
            done_pulse = 1'b1;
            idx_d      = wrap_q ? '0 : idx_q + 1'b1;
            st_d       = ENG_FETCH;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        if (!stop_req) st_d = ENG_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      ptr_q  <= '0;
      last_q <= 1'b0;
      crc_q  <= 1'b0;
      wrap_q <= 1'b0;
    end else if (load) begin
      len_q  <= rd_len;
      ptr_q  <= rd_ptr;
      last_q <= rd_last;
      crc_q  <= rd_crc;
      wrap_q <= rd_wrap;
    end
  end

  assign rd_idx     = idx_q;
  assign frame_sent = done_pulse && last_q;
  assign m_valid    = (st_q == ENG_SEND);
  assign buf_addr   = ptr_q + AW'(cnt_q);
  assign m_data     = buf_data;
  assign m_last     = m_valid && byte_end && last_q;
  assign m_crc      = m_valid && crc_q;
endmodule

// File: rtl/txr_events.sv
module txr_events
  import txr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] ev_set,
  input  logic [EV_W-1:0] ev_clr,
  output logic [EV_W-1:0] ev_q
);
  logic [EV_W-1:0] ev_d;

  for (genvar b = 0; b < EV_W; b++) begin : g_bit
    assign ev_d[b] = ev_set[b] | (ev_q[b] & ~ev_clr[b]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= ev_d;
  end
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int RING_N  = 4,
  parameter int LEN_W   = 11,
  parameter int AW      = 16,
  parameter int MAX_LEN = 1500,
  localparam int IW     = (RING_N > 1) ? $clog2(RING_N) : 1,
  localparam int CW     = $clog2(RING_N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sub_valid,
  input  logic [LEN_W-1:0] sub_len,
  input  logic [AW-1:0]    sub_ptr,
  output logic             sub_ok,
  input  logic             kick,
  input  logic             stop_req,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [7:0]       m_data,
  output logic             m_last,
  output logic             m_crc,
  output logic [AW-1:0]    buf_addr,
  input  logic [7:0]       buf_data,
  output logic [CW-1:0]    free_cnt,
  output logic [EV_W-1:0]  evt,
  input  logic [EV_W-1:0]  evt_clr
);
  logic [IW-1:0]    rd_idx;
  logic             rd_ready, rd_wrap, rd_last, rd_crc, done_pulse;
  logic             frame_sent, stop_done;
  logic [LEN_W-1:0] rd_len;
  logic [AW-1:0]    rd_ptr;
  logic [EV_W-1:0]  ev_set;

  txr_desc_ring #(.RING_N(RING_N), .LEN_W(LEN_W), .AW(AW), .MAX_LEN(MAX_LEN)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .sub_valid(sub_valid), .sub_len(sub_len), .sub_ptr(sub_ptr), .sub_ok(sub_ok),
    .rd_idx(rd_idx), .rd_ready(rd_ready), .rd_wrap(rd_wrap), .rd_last(rd_last),
    .rd_crc(rd_crc), .rd_len(rd_len), .rd_ptr(rd_ptr),
    .done_pulse(done_pulse), .done_idx(rd_idx), .free_cnt(free_cnt)
  );

  txr_fetch #(.RING_N(RING_N), .LEN_W(LEN_W), .AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .kick(kick), .stop_req(stop_req),
    .rd_idx(rd_idx), .rd_ready(rd_ready), .rd_wrap(rd_wrap), .rd_last(rd_last),
    .rd_crc(rd_crc), .rd_len(rd_len), .rd_ptr(rd_ptr),
    .done_pulse(done_pulse), .frame_sent(frame_sent), .stop_done(stop_done),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .m_crc(m_crc), .buf_addr(buf_addr), .buf_data(buf_data)
  );

  always_comb begin
    ev_set          = '0;
    ev_set[EV_SENT] = frame_sent;
    ev_set[EV_STOP] = stop_done;
  end

  txr_events u_events (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .ev_clr(evt_clr), .ev_q(evt)
  );
endmodule

// File: rtl/txr_engine_chk.sv
module txr_engine_chk #(
  parameter int RING_N  = 4,
  parameter int LEN_W   = 11,
  parameter int MAX_LEN = 1500,
  localparam int CW     = $clog2(RING_N + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sub_ok,
  input logic [LEN_W-1:0] sub_len,
  input logic             stop_req,
  input logic             m_valid,
  input logic             m_ready,
  input logic [7:0]       m_data,
  input logic             m_last,
  input logic             m_crc,
  input logic [CW-1:0]    free_cnt,
  input logic [1:0]       evt,
  input logic [1:0]       evt_clr
);
  assert_free_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CW'(RING_N));

  assert_accept_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sub_ok |-> (free_cnt != '0) && (sub_len != '0) && (sub_len <= LEN_W'(MAX_LEN)));

  assert_hold_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last) && $stable(m_crc)));

  assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !m_valid) |=> !m_valid);

  assert_event_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[0] && !evt_clr[0]) |=> evt[0]);
endmodule

bind txr_engine txr_engine_chk #(.RING_N(RING_N), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .sub_ok(sub_ok), .sub_len(sub_len), .stop_req(stop_req),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
  .m_crc(m_crc), .free_cnt(free_cnt), .evt(evt), .evt_clr(evt_clr)
);

// File: tb/txr_engine_bench.sv
module txr_engine_bench;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sub_valid = 1'b0;
  logic [10:0] sub_len = '0;
  logic [15:0] sub_ptr = '0;
  logic        sub_ok;
  logic        kick = 1'b0;
  logic        stop_req = 1'b0;
  logic        m_valid, m_ready = 1'b0, m_last, m_crc;
  logic [7:0]  m_data, buf_data;
  logic [15:0] buf_addr;
  logic [2:0]  free_cnt;
  logic [1:0]  evt, evt_clr = '0;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [7:0] got [64];
  int   got_n;
  logic last_ok, crc_ok;

  always #2.5 clk = ~clk;

  assign buf_data = buf_addr[7:0] ^ buf_addr[15:8] ^ 8'h5A;

  function automatic logic [7:0] mem_at(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  txr_engine u_txr_engine (
    .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_len(sub_len), .sub_ptr(sub_ptr),
    .sub_ok(sub_ok), .kick(kick), .stop_req(stop_req), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_last(m_last), .m_crc(m_crc), .buf_addr(buf_addr), .buf_data(buf_data),
    .free_cnt(free_cnt), .evt(evt), .evt_clr(evt_clr)
  );

  task automatic summary_and_end();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog: act=%0d exp<=100000", cyc);
      summary_and_end();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic submit(input int len, input logic [15:0] ptr, input bit exp_ok, input string req);
    @(negedge clk);
    sub_valid = 1'b1; sub_len = 11'(len); sub_ptr = ptr;
    #1;
    chk(sub_ok == exp_ok, req, int'(sub_ok), int'(exp_ok));
    @(negedge clk);
    sub_valid = 1'b0;
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  // Collect one buffer; bp=1 throttles the sink.
  task automatic collect(input int len, input bit bp);
    int guard = 0;
    bit tgl = 1'b0;
    got_n = 0; last_ok = 1'b1; crc_ok = 1'b1;
    while (got_n < len && guard < 2000) begin
      @(negedge clk);
      tgl = ~tgl;
      m_ready = bp ? tgl : 1'b1;
      #1;
      if (m_valid && m_ready) begin
        got[got_n] = m_data;
        if (m_last != (got_n == len - 1)) last_ok = 1'b0;
        if (!m_crc) crc_ok = 1'b0;
        got_n = got_n + 1;
      end
      guard = guard + 1;
    end
    @(negedge clk);
    m_ready = 1'b0;
  endtask

  task automatic check_frame(input int len, input logic [15:0] ptr, input string req);
    int errs = 0;
    for (int i = 0; i < len; i++)
      if (i >= got_n || got[i] != mem_at(ptr + 16'(i))) errs = errs + 1;
    chk(got_n == len && errs == 0, req, got_n - errs, len);
  endtask

  task automatic idle_quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (m_valid) seen = seen + 1;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(free_cnt == 3'(N), "R1 free", int'(free_cnt), N);
    chk(evt == 2'b00, "R1 evt", int'(evt), 0);
    chk(!m_valid, "R1 valid", int'(m_valid), 0);
  endtask

  task automatic t_reject();
    submit(0, 16'h0100, 1'b0, "R2 len0");
    submit(1501, 16'h0100, 1'b0, "R2 len1501");
    chk(free_cnt == 3'(N), "R2 free kept", int'(free_cnt), N);
    pulse_kick();
    idle_quiet(8, "R2 nothing sent");
  endtask

  task automatic t_basic();
    submit(3, 16'h1230, 1'b1, "R2 accept");
    idle_quiet(5, "R3 idle before kick");
    pulse_kick();
    collect(3, 1'b0);
    check_frame(3, 16'h1230, "R3 bytes");
    chk(last_ok, "R4 last marker", int'(last_ok), 1);
    chk(crc_ok, "R4 crc flag", int'(crc_ok), 1);
    chk(evt[0] == 1'b1, "R10 sent event", int'(evt[0]), 1);
    idle_quiet(4, "R3 stop at not-ready");
    chk(free_cnt == 3'(N), "R7 reclaimed", int'(free_cnt), N);
  endtask

  task automatic t_w1c();
    @(negedge clk); evt_clr = 2'b01;
    @(negedge clk); evt_clr = 2'b00;
    chk(evt == 2'b00, "R10 w1c", int'(evt), 0);
  endtask

  task automatic t_backpressure();
    submit(7, 16'h4410, 1'b1, "R2 accept bp");
    pulse_kick();
    collect(7, 1'b1);
    check_frame(7, 16'h4410, "R5 bytes under backpressure");
    chk(last_ok, "R5 last under backpressure", int'(last_ok), 1);
  endtask

  task automatic t_full();
    for (int k = 0; k < N; k++)
      submit(2 + k, 16'h2000 + 16'(k * 16), 1'b1, "R2 fill");
    submit(5, 16'h2F00, 1'b0, "R2 full refuse");
    repeat (4) @(negedge clk);
    chk(free_cnt == 3'd0, "R7 unsent stay used", int'(free_cnt), 0);
    pulse_kick();
    for (int k = 0; k < N; k++) begin
      collect(2 + k, 1'b0);
      check_frame(2 + k, 16'h2000 + 16'(k * 16), "R6 ring order");
    end
    repeat (4) @(negedge clk);
    chk(free_cnt == 3'(N), "R7 all back", int'(free_cnt), N);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 6; k++) begin
      submit(2, 16'h3000 + 16'(k * 8), 1'b1, "R6 submit");
      pulse_kick();
      collect(2, 1'b0);
      check_frame(2, 16'h3000 + 16'(k * 8), "R6 wrap pass");
    end
  endtask

  task automatic t_same_cycle();
    int f0;
    int guard = 0;
    submit(1, 16'h5500, 1'b1, "R8 first");
    pulse_kick();
    @(negedge clk);
    while (!m_valid && guard < 50) begin @(negedge clk); guard++; end
    m_ready = 1'b1; evt_clr = 2'b01;
    @(negedge clk);
    m_ready = 1'b0; evt_clr = 2'b00;
    chk(evt[0] == 1'b1, "R10 set beats clear", int'(evt[0]), 1);
    f0 = int'(free_cnt);
    sub_valid = 1'b1; sub_len = 11'd2; sub_ptr = 16'h5600;
    @(negedge clk);
    sub_valid = 1'b0;
    chk(int'(free_cnt) == f0, "R8 submit+reclaim", int'(free_cnt), f0);
    pulse_kick();
    collect(2, 1'b0);
    check_frame(2, 16'h5600, "R8 second frame");
  endtask

  task automatic t_stop();
    int guard = 0;
    submit(6, 16'h6600, 1'b1, "R9 frame A");
    submit(2, 16'h6700, 1'b1, "R9 frame B");
    pulse_kick();
    while (!m_valid && guard < 50) begin @(negedge clk); guard++; end
    stop_req = 1'b1;
    collect(6, 1'b0);
    check_frame(6, 16'h6600, "R9 current frame completes");
    pulse_kick();
    idle_quiet(10, "R9 halted");
    chk(evt[1] == 1'b1, "R9 stop event", int'(evt[1]), 1);
    stop_req = 1'b0;
    @(negedge clk); evt_clr = 2'b11;
    @(negedge clk); evt_clr = 2'b00;
    pulse_kick();
    collect(2, 1'b0);
    check_frame(2, 16'h6700, "R9 resumes");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reject();
    t_basic();
    t_w1c();
    t_backpressure();
    t_full();
    t_wrap();
    t_same_cycle();
    t_stop();
    repeat (4) @(negedge clk);
    summary_and_end();
  end
endmodule